// File: doc/BRIEF.md
# Polar Constituent Node Decoder

This block decodes one node of a simplified successive-cancellation polar decoder tree in a single operation. The scheduler hands it the node's soft values (a vector of signed LLRs, one per position, Nv a power of two up to `MAX_NV`) together with the node's packed frozen mask. The block does not descend into the subtree below the node. It inspects the mask with whole-vector compares and recognises an all-frozen node, an all-information node, a repetition node or a single-parity-check node. It then runs the matching shortcut decoder.

For every recognised node the block returns two bit vectors. The first is the hard-decision vector `beta`. The second is its re-encoded codeword, produced by an in-place polar butterfly transform. A node that matches no pattern is normally reported back with a flag so that the scheduler can split it. When pruning is enabled and the node has the configured pruning size (4 or 8), such a node is instead decoded by plain hard decision followed by the transform. Each node is framed by a one-cycle `start` pulse and a one-cycle `done` pulse. The block accepts a new node on every cycle.

Top module: `polar_node_decoder`

## Requirements
- R1: Bit i of `frozen_mask` describes node position i, where 1 means frozen and 0 means information. Only positions below Nv = 2^`node_log` are considered, and `node_log` values above log2(`MAX_NV`) act as log2(`MAX_NV`). The classes are checked in priority order all-frozen, all-information, repetition, single-parity, and each is reported on `node_kind` as 0, 1, 2 and 3 respectively. A pruned hard-decision node reports 4, and an unrecognised node reports 5.
- R2: An all-frozen node (kind 0) gives all-zero `beta` and `codeword`.
- R3: An all-information node (kind 1) has `beta[i]` = 1 exactly when LLR i is negative. Its `codeword` is the transform of `beta`.
- R4: A repetition node (kind 2) has every position frozen except the last one, Nv-1. Its `beta[Nv-1]` is 1 exactly when the sum of all Nv LLRs is negative, and all its other bits are 0. The sum is formed without 16-bit wrap-around, so 8 LLRs of 30000 plus 8 of -100 decide 0.
- R5: A single-parity node (kind 3) has position 0 as its only frozen position. It takes the hard decisions of all positions. If an odd number of them are 1, it inverts the bit at the position of smallest LLR magnitude, choosing the lowest index on a tie. The magnitude of -32768 counts as 32768.
- R6: `codeword[i]` is the XOR of `beta[j]` over every j < Nv whose set bits include all set bits of i. Positions at or above Nv read 0 in both vectors.
- R7: With `prune_en` = 1, an unrecognised node whose Nv equals the pruning size gives kind 4. The pruning size is 8 when `prune_big` = 1 and 4 otherwise. Such a node has a hard-decision `beta` as in R3 and the matching transform.
- R8: An unrecognised node that is not pruned gives kind 5, raises `not_special`, and gives all-zero `beta` and `codeword`.
- R9: `done` rises exactly two clock edges after the edge that samples `start`, for one cycle per start. The outputs change only in that cycle and hold until the next `done`.
- R10: After reset, `done`, `not_special`, `node_kind`, `beta` and `codeword` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse: sample a node on this edge |
| node_log | input | 3 | log2 of node size Nv |
| frozen_mask | input | MAX_NV (16) | Packed frozen mask, 1 = frozen |
| llr_vec | input | MAX_NV*LLR_W (256) | LLR i at bits [i*16 +: 16], two's complement |
| prune_en | input | 1 | Enable hard-decision fallback for unrecognised nodes |
| prune_big | input | 1 | Pruning size select: 1 = 8, 0 = 4 |
| done | output | 1 | One-cycle pulse: results valid |
| not_special | output | 1 | Unrecognised node, not decoded |
| node_kind | output | 3 | Node class code (see R1) |
| beta | output | MAX_NV (16) | Hard-decision vector |
| codeword | output | MAX_NV (16) | Polar transform of `beta` |

## Verification
Every result appears on the second rising edge after the edge that sees `start`. That edge carries one input register and one output register. The bench drives inputs on falling edges. It expects `done` low at the first falling edge after the start pulse, and samples `done`, the class, `not_special`, `beta` and `codeword` at the second falling edge. One falling edge later it checks that `done` has dropped and that `beta` and `codeword` have held.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [2:0] {
    KIND_RATE0 = 3'd0,
    KIND_RATE1 = 3'd1,
    KIND_REP   = 3'd2,
    KIND_SPC   = 3'd3,
    KIND_HARD  = 3'd4,
    KIND_NONE  = 3'd5
  } node_kind_e;

endpackage

// File: rtl/pcd_classify.sv
module pcd_classify
  import pcd_pkg::*;
#(
  parameter int MAX_NV = 16,
  parameter int LNW    = 3
) (
  input  logic [LNW-1:0]    node_log,
  input  logic [MAX_NV-1:0] frozen,
  input  logic              prune_en,
  input  logic              prune_big,
  output node_kind_e        kind,
  output logic [MAX_NV-1:0] valid,
  output logic [MAX_NV-1:0] last_pos
);

  localparam int LOG_MAX = $clog2(MAX_NV);

  logic [LNW-1:0]    log_eff;
  logic [MAX_NV-1:0] eff;
  logic              is_r0, is_r1, is_rep, is_spc, prune_hit;

  assign log_eff = (node_log > LNW'(LOG_MAX)) ? LNW'(LOG_MAX) : node_log;

  // positions inside the node
  for (genvar gi = 0; gi < MAX_NV; gi++) begin : g_valid
    assign valid[gi] = (32'(gi) < (32'd1 << log_eff));
  end

  assign last_pos = valid & ~(valid >> 1);
  assign eff      = frozen & valid;

  assign is_r0  = (eff == valid);
  assign is_r1  = (eff == '0);
  assign is_rep = (eff == (valid & ~last_pos));
  assign is_spc = (eff == MAX_NV'(1));

  assign prune_hit = prune_en && (log_eff == (prune_big ? LNW'(3) : LNW'(2)));

  always_comb begin
    if (is_r0)          kind = KIND_RATE0;
    else if (is_r1)     kind = KIND_RATE1;
    else if (is_rep)    kind = KIND_REP;
    else if (is_spc)    kind = KIND_SPC;
    else if (prune_hit) kind = KIND_HARD;
    else                kind = KIND_NONE;
  end

endmodule

// File: rtl/pcd_softstats.sv
module pcd_softstats #(
  parameter int MAX_NV = 16,
  parameter int LLR_W  = 16
) (
  input  logic [MAX_NV*LLR_W-1:0] llr_vec,
  input  logic [MAX_NV-1:0]       valid,
  output logic [MAX_NV-1:0]       hd,
  output logic                    sum_neg,
  output logic                    parity,
  output logic [MAX_NV-1:0]       min_onehot
);

  localparam int LOG_MAX = $clog2(MAX_NV);
  localparam int SUM_W   = LLR_W + LOG_MAX + 1;
  localparam int MAGW    = LLR_W + 1;
  localparam int IDXW    = (LOG_MAX > 0) ? LOG_MAX : 1;

  logic signed [SUM_W-1:0] acc;
  logic [LLR_W-1:0]        elem;
  logic [MAGW-1:0]         ext, mag, best_mag;
  logic [IDXW-1:0]         best_idx;

  always_comb begin
    acc      = '0;
    elem     = '0;
    ext      = '0;
    mag      = '0;
    best_mag = '1;
    best_idx = '0;
    hd       = '0;
    for (int i = 0; i < MAX_NV; i++) begin
      elem = llr_vec[i*LLR_W +: LLR_W];
      ext  = {elem[LLR_W-1], elem};
      mag  = elem[LLR_W-1] ? (~ext + 1'b1) : ext;
      if (valid[i]) begin
        hd[i] = elem[LLR_W-1];
        acc   = acc + SUM_W'($signed(elem));
        // strict compare keeps the lowest index on ties
        if (mag < best_mag) begin
          best_mag = mag;
          best_idx = IDXW'(i);
        end
      end
    end
  end

  always_comb begin
    min_onehot           = '0;
    min_onehot[best_idx] = 1'b1;
  end

  assign sum_neg = acc[SUM_W-1];
  assign parity  = ^hd;

endmodule

// File: rtl/pcd_xform.sv
module pcd_xform #(
  parameter int MAX_NV = 16
) (
  input  logic [MAX_NV-1:0] bits_in,
  output logic [MAX_NV-1:0] bits_out
);

  localparam int LOG_MAX = $clog2(MAX_NV);

  logic [LOG_MAX:0][MAX_NV-1:0] stage;

  assign stage[0] = bits_in;

  for (genvar s = 0; s < LOG_MAX; s++) begin : g_stage
    for (genvar i = 0; i < MAX_NV; i++) begin : g_bit
      if (((i >> s) & 1) == 0) begin : g_low
        assign stage[s+1][i] = stage[s][i] ^ stage[s][i + (1 << s)];
      end else begin : g_high
        assign stage[s+1][i] = stage[s][i];
      end
    end
  end

  assign bits_out = stage[LOG_MAX];

endmodule

// File: rtl/polar_node_decoder.sv
module polar_node_decoder
  import pcd_pkg::*;
#(
  parameter  int MAX_NV  = 16,
  parameter  int LLR_W   = 16,
  localparam int LOG_MAX = $clog2(MAX_NV),
  localparam int LNW     = $clog2(LOG_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LNW-1:0]          node_log,
  input  logic [MAX_NV-1:0]       frozen_mask,
  input  logic [MAX_NV*LLR_W-1:0] llr_vec,
  input  logic                    prune_en,
  input  logic                    prune_big,
  output logic                    done,
  output logic                    not_special,
  output logic [2:0]              node_kind,
  output logic [MAX_NV-1:0]       beta,
  output logic [MAX_NV-1:0]       codeword
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // input stage
  logic                    vld_q;
  logic [MAX_NV*LLR_W-1:0] llr_q;
  logic [MAX_NV-1:0]       mask_q;
  logic [LNW-1:0]          log_q;
  logic                    pe_q, pb_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) vld_q <= 1'b0;
    else         vld_q <= start;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      llr_q  <= llr_vec;
      mask_q <= frozen_mask;
      log_q  <= node_log;
      pe_q   <= prune_en;
      pb_q   <= prune_big;
    end
  end

  // decode datapath
  node_kind_e        kind_c;
  logic [MAX_NV-1:0] valid_c, last_c;
  logic [MAX_NV-1:0] hd_c, min_c;
  logic              sum_neg_c, parity_c;
  logic [MAX_NV-1:0] beta_n, code_n;
  logic              ns_n;

  pcd_classify #(.MAX_NV(MAX_NV), .LNW(LNW)) u_classify (
    .node_log (log_q),
    .frozen   (mask_q),
    .prune_en (pe_q),
    .prune_big(pb_q),
    .kind     (kind_c),
    .valid    (valid_c),
    .last_pos (last_c)
  );

  pcd_softstats #(.MAX_NV(MAX_NV), .LLR_W(LLR_W)) u_stats (
    .llr_vec   (llr_q),
    .valid     (valid_c),
    .hd        (hd_c),
    .sum_neg   (sum_neg_c),
    .parity    (parity_c),
    .min_onehot(min_c)
  );

  always_comb begin
    ns_n = 1'b0;
    unique case (kind_c)
      KIND_RATE0: beta_n = '0;
      KIND_RATE1: beta_n = hd_c;
      KIND_REP:   beta_n = sum_neg_c ? last_c : '0;
      KIND_SPC:   beta_n = hd_c ^ (parity_c ? min_c : '0);
      KIND_HARD:  beta_n = hd_c;
      default: begin
        beta_n = '0;
        ns_n   = 1'b1;
      end
    endcase
  end

  pcd_xform #(.MAX_NV(MAX_NV)) u_xform (
    .bits_in (beta_n),
    .bits_out(code_n)
  );

  // output stage
  logic              done_q, ns_q;
  logic [2:0]        kind_q;
  logic [MAX_NV-1:0] beta_q, code_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done_q <= 1'b0;
      ns_q   <= 1'b0;
      kind_q <= '0;
      beta_q <= '0;
      code_q <= '0;
    end else begin
      done_q <= vld_q;
      if (vld_q) begin
        ns_q   <= ns_n;
        kind_q <= kind_c;
        beta_q <= beta_n;
        code_q <= code_n;
      end
    end
  end

  assign done        = done_q;
  assign not_special = ns_q;
  assign node_kind   = kind_q;
  assign beta        = beta_q;
  assign codeword    = code_q;

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int MAX_NV = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              start,
  input logic              done,
  input logic              not_special,
  input logic [2:0]        node_kind,
  input logic [MAX_NV-1:0] beta,
  input logic [MAX_NV-1:0] codeword
);

  // R9: result two edges after the sampling edge
  a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_sn)
    start |-> ##2 done);

  // R9: outputs hold between results
  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_sn)
    !done |-> ($stable(beta) && $stable(codeword)));

  // R2: all-frozen node emits nothing
  a_r2_rate0_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && node_kind == 3'd0) |-> (beta == '0 && codeword == '0));

  // R4: repetition node carries at most one set bit
  a_r4_rep_single: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && node_kind == 3'd2) |-> ($countones(beta) <= 1));

  // R5: parity node result has even weight
  a_r5_spc_even: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && node_kind == 3'd3) |-> (^beta == 1'b0));

  // R6: transform of zero is zero
  a_r6_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && beta == '0) |-> (codeword == '0));

  // R8: flag only with the unrecognised class and empty vectors
  a_r8_none_flag: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && not_special) |-> (node_kind == 3'd5 && beta == '0 && codeword == '0));

endmodule

bind polar_node_decoder pcd_checker #(.MAX_NV(MAX_NV)) u_pcd_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .start      (start),
  .done       (done),
  .not_special(not_special),
  .node_kind  (node_kind),
  .beta       (beta),
  .codeword   (codeword)
);

// File: tb/tb_polar_node_decoder.sv
module tb_polar_node_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int LW = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start;
  logic [2:0]          node_log;
  logic [NV-1:0]       frozen_mask;
  logic [NV*LW-1:0]    llr_vec;
  logic                prune_en, prune_big;
  logic                done, not_special;
  logic [2:0]          node_kind;
  logic [NV-1:0]       beta, codeword;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  polar_node_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .node_log(node_log),
    .frozen_mask(frozen_mask), .llr_vec(llr_vec), .prune_en(prune_en),
    .prune_big(prune_big), .done(done), .not_special(not_special),
    .node_kind(node_kind), .beta(beta), .codeword(codeword)
  );

  typedef struct packed {
    logic [2:0]  lg;
    logic [15:0] mask;
    logic        pe;
    logic        pb;
    logic [15:0] seed;
    logic [2:0]  kind;
  } vec_t;

  localparam int NROW = 12;
  localparam vec_t TBL [NROW] = '{
    '{3'd4, 16'hFFFF, 1'b0, 1'b0, 16'h1234, 3'd0},  // R2 all frozen
    '{3'd4, 16'h0000, 1'b0, 1'b0, 16'h9E37, 3'd1},  // R3 all info
    '{3'd3, 16'h007F, 1'b0, 1'b0, 16'h4F1B, 3'd2},  // R4 repetition
    '{3'd3, 16'h0001, 1'b0, 1'b0, 16'hC3A5, 3'd3},  // R5 parity
    '{3'd2, 16'h0005, 1'b1, 1'b0, 16'h7777, 3'd4},  // R7 prune 4
    '{3'd3, 16'h0055, 1'b1, 1'b0, 16'h2468, 3'd5},  // R8 size mismatch
    '{3'd3, 16'h0055, 1'b1, 1'b1, 16'h2468, 3'd4},  // R7 prune 8
    '{3'd2, 16'h0005, 1'b0, 1'b0, 16'h7777, 3'd5},  // R8 no prune
    '{3'd4, 16'h7FFF, 1'b0, 1'b0, 16'hBEEF, 3'd2},  // R4 size 16
    '{3'd1, 16'h0001, 1'b0, 1'b0, 16'h0F0F, 3'd2},  // R1 rep before parity
    '{3'd4, 16'h0001, 1'b0, 1'b0, 16'h5A5A, 3'd3},  // R5 size 16
    '{3'd2, 16'hFFF0, 1'b0, 1'b0, 16'h3C3C, 3'd1}   // R1 mask above Nv ignored
  };

  function automatic logic [15:0] gen_llr(logic [15:0] seed, int i);
    return (seed * 16'(i*7+1)) ^ 16'(i << 11);
  endfunction

  // independent behavioural model
  function automatic void model(input int lg, input logic [15:0] mask,
                                input logic pe, input logic pb,
                                input logic [15:0][15:0] l,
                                output logic [2:0] k, output logic ns,
                                output logic [15:0] b, output logic [15:0] c);
    int nv, nf, best, bm, mg;
    longint sum;
    logic par;
    logic [15:0] hd;
    nv = 1 << lg; nf = 0; best = 0; bm = 1 << 20; sum = 0; par = 1'b0; hd = '0;
    for (int i = 0; i < nv; i++) begin
      nf += int'(mask[i]);
      hd[i] = l[i][15];
      sum += longint'($signed(l[i]));
      mg = l[i][15] ? -int'($signed(l[i])) : int'(l[i]);
      if (mg < bm) begin bm = mg; best = i; end
      par ^= hd[i];
    end
    ns = 1'b0; b = '0;
    if (nf == nv)                                   k = 3'd0;
    else if (nf == 0)                             begin k = 3'd1; b = hd; end
    else if (nf == nv-1 && !mask[nv-1])           begin k = 3'd2; b[nv-1] = (sum < 0); end
    else if (nf == 1 && mask[0])                  begin k = 3'd3; b = hd; if (par) b[best] = ~b[best]; end
    else if (pe && lg == (pb ? 3 : 2))            begin k = 3'd4; b = hd; end
    else                                          begin k = 3'd5; ns = 1'b1; end
    for (int i = 0; i < 16; i++) begin
      c[i] = 1'b0;
      for (int j = 0; j < 16; j++) if ((j & i) == i) c[i] ^= b[j];
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_node(input int lg, input logic [15:0] mask, input logic pe,
                          input logic pb, input logic [15:0][15:0] l,
                          input logic [2:0] exp_kind_tbl, input bit use_tbl,
                          input string tag);
    logic [2:0] ek; logic ens; logic [15:0] eb, ec, hb, hc;
    model(lg, mask, pe, pb, l, ek, ens, eb, ec);
    if (use_tbl) check(ek == exp_kind_tbl, {tag, " R1 table class"}, 32'(ek), 32'(exp_kind_tbl));
    @(negedge clk);
    node_log = 3'(lg); frozen_mask = mask; prune_en = pe; prune_big = pb;
    for (int i = 0; i < NV; i++) llr_vec[i*LW +: LW] = l[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, {tag, " R9 early done"}, 32'(done), 32'd0);
    @(negedge clk);
    check(done == 1'b1, {tag, " R9 done"}, 32'(done), 32'd1);
    check(node_kind == ek, {tag, " R1 kind"}, 32'(node_kind), 32'(ek));
    check(not_special == ens, {tag, " R8 flag"}, 32'(not_special), 32'(ens));
    check(beta == eb, {tag, " R3 beta"}, 32'(beta), 32'(eb));
    check(codeword == ec, {tag, " R6 codeword"}, 32'(codeword), 32'(ec));
    hb = beta; hc = codeword;
    @(negedge clk);
    check(done == 1'b0 && beta == hb && codeword == hc, {tag, " R9 hold"},
          {15'd0, done, beta}, {16'd0, hb});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0][15:0] l;
    rst_n = 1'b0; start = 1'b0; node_log = '0; frozen_mask = '0; llr_vec = '0;
    prune_en = 1'b0; prune_big = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 0 && not_special == 0 && node_kind == 0, "R10 reset flags",
          {28'd0, done, not_special, node_kind[1:0]}, 32'd0);
    check(beta == 0 && codeword == 0, "R10 reset vectors", {beta, codeword}, 32'd0);

    for (int r = 0; r < NROW; r++) begin
      for (int i = 0; i < 16; i++) l[i] = gen_llr(TBL[r].seed, i);
      run_node(int'(TBL[r].lg), TBL[r].mask, TBL[r].pe, TBL[r].pb, l,
               TBL[r].kind, 1'b1, $sformatf("row%0d", r));
    end

    // R5 tie: all magnitudes 5, odd parity -> flip index 0
    l = '0;
    l[0] = -16'sd5; l[1] = 16'sd5; l[2] = -16'sd5; l[3] = -16'sd5;
    run_node(2, 16'h0001, 1'b0, 1'b0, l, 3'd3, 1'b0, "R5 tie");
    check(beta[3:0] == 4'b1100, "R5 tie lowest index", 32'(beta), 32'hC);

    // R4 wide sum: 16-bit wrap would give the opposite decision
    for (int i = 0; i < 16; i++) l[i] = (i < 8) ? 16'sd30000 : -16'sd100;
    run_node(4, 16'h7FFF, 1'b0, 1'b0, l, 3'd2, 1'b0, "R4 wide pos");
    check(beta == 16'h0000 && codeword == 16'h0000, "R4 wide pos zero", {beta, codeword}, 32'd0);
    for (int i = 0; i < 16; i++) l[i] = (i < 8) ? -16'sd30000 : 16'sd100;
    run_node(4, 16'h7FFF, 1'b0, 1'b0, l, 3'd2, 1'b0, "R4 wide neg");
    check(beta == 16'h8000 && codeword == 16'hFFFF, "R4 wide neg one",
          {beta, codeword}, 32'h8000FFFF);
    for (int i = 0; i < 16; i++) l[i] = 16'h8000;
    run_node(4, 16'h7FFF, 1'b0, 1'b0, l, 3'd2, 1'b0, "R4 full scale");

    // R2 small all-frozen node with negative LLRs
    for (int i = 0; i < 16; i++) l[i] = -16'sd7;
    run_node(1, 16'h0003, 1'b1, 1'b0, l, 3'd0, 1'b0, "R2 small");

    // R5 minimum at -32768 magnitude is largest, not smallest
    l = '0;
    for (int i = 0; i < 8; i++) l[i] = 16'sd900;
    l[0] = 16'h8000; l[5] = 16'sd3;
    run_node(3, 16'h0001, 1'b0, 1'b0, l, 3'd3, 1'b0, "R5 extreme");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule